// File: doc/BRIEF.md
# Running-Disparity Tracker and Idle Selector

This block sits in front of a two-byte-per-cycle 8b/10b encoder that cannot report its own running disparity. Each cycle it takes a 16-bit word and a per-byte control flag. It looks up both bytes in parallel to learn whether their 10-bit codes would invert the running disparity, and registers that result. From these bits and the disparity left by the previous word, it derives the disparity each byte must be encoded with and the disparity left at the end of the word. The external encoder uses these values as force-disparity controls.

The low byte goes onto the line first, which is why a comma is placed there. When an idle is requested, the block replaces that cycle's word with an idle ordered set: K28.5 in the low byte and a data character in the high byte. The data character is picked from the current running disparity so that the comma has the polarity the receiver synchronizes on. Both idle forms leave the running disparity negative. The data word and its control flags are delayed one cycle so that they line up with the disparity outputs.

Top module: `rd_idle_sel`

## Requirements
- R1: While reset is asserted, `disp_lo` and `disp_end` are 0 and `word_out` is 0. Disparity is encoded as 1 = positive and 0 = negative, so running disparity starts negative.
- R2: When `idle_req` is low, `word_out` and `ctl_out` are equal to `word_in` and `ctl_in` from one clock earlier.
- R3: `disp_lo` is the running disparity at the end of the previously output word.
- R4: For a data word, `disp_hi` equals `disp_lo` XOR the flip bit of the low byte.
- R5: `disp_end` equals `disp_hi` XOR the flip bit of the high byte, and it becomes `disp_lo` in the next cycle.
- R6: The flip bit of a byte whose control flag is clear is A XOR B. A is 1 when bits [4:0] are one of 0, 1, 2, 4, 8, 15, 16, 23, 24, 27, 29, 30 or 31. B is 1 when bits [7:5] are 0, 4 or 7.
- R7: A byte whose control flag is set (`ctl_in` bit 0 for the low byte, bit 1 for the high byte) is treated as K28.5 and has flip bit 1, whatever its value.
- R8: One cycle after `idle_req` is high, `word_out[7:0]` is 8'hBC and `ctl_out` is 2'b01. `word_out[15:8]` is 8'hC5 (D5.6) when `disp_lo` is 1 and 8'h50 (D16.2) when `disp_lo` is 0. `disp_hi` is the inverse of `disp_lo`. The `word_in` and `ctl_in` of that cycle are ignored.
- R9: After an idle ordered set, `disp_end` is 0, so the following word starts with `disp_lo` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| word_in | input | 16 | Word to transmit; the low byte goes first |
| ctl_in | input | 2 | Per-byte control flag (bit 0 is the low byte) |
| idle_req | input | 1 | Send an idle ordered set in place of this word |
| word_out | output | 16 | Word to the encoder, delayed one cycle |
| ctl_out | output | 2 | Control flags to the encoder, delayed one cycle |
| disp_lo | output | 1 | Disparity to force when encoding the low byte |
| disp_hi | output | 1 | Disparity to force when encoding the high byte |
| disp_end | output | 1 | Running disparity after the current output word |

## Verification
Idle selection and disparity chaining meet in one cycle. The idle choice depends on the disparity that the previous word's registered flip bits have just produced. The same cycle must also reset the chain to negative for the word that follows. The bench provokes this with random data that has idles scattered among it, including back-to-back idles and control-flagged bytes right before an idle, so both idle forms occur after words ending in either polarity. A scoreboard model applies the flip rule on its own and judges every output field of every word in order.

// File: rtl/rd_idle_sel.sv
module rd_idle_sel (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] word_in,
  input  logic [1:0]  ctl_in,
  input  logic        idle_req,
  output logic [15:0] word_out,
  output logic [1:0]  ctl_out,
  output logic        disp_lo,
  output logic        disp_hi,
  output logic        disp_end
);

  localparam logic [7:0] COMMA   = 8'hBC;
  localparam logic [7:0] IDLE_RP = 8'hC5;
  localparam logic [7:0] IDLE_RN = 8'h50;

  function automatic logic flip_of(input logic [7:0] b, input logic is_k);
    logic u5, u3;
    case (b[4:0])
      5'd0, 5'd1, 5'd2, 5'd4, 5'd8, 5'd15, 5'd16, 5'd23,
      5'd24, 5'd27, 5'd29, 5'd30, 5'd31: u5 = 1'b1;
      default: u5 = 1'b0;
    endcase
    case (b[7:5])
      3'd0, 3'd4, 3'd7: u3 = 1'b1;
      default: u3 = 1'b0;
    endcase
    return is_k ? 1'b1 : (u5 ^ u3);
  endfunction

  logic [15:0] word_q;
  logic [1:0]  ctl_q;
  logic        idle_q, flo_q, fhi_q, rd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      ctl_q  <= '0;
      idle_q <= 1'b0;
      flo_q  <= 1'b0;
      fhi_q  <= 1'b0;
      rd_q   <= 1'b0;
    end else begin
      word_q <= word_in;
      ctl_q  <= ctl_in;
      idle_q <= idle_req;
      flo_q  <= flip_of(word_in[7:0], ctl_in[0]);
      fhi_q  <= flip_of(word_in[15:8], ctl_in[1]);
      rd_q   <= disp_end;
    end
  end

  assign disp_lo  = rd_q;
  assign word_out = idle_q ? {(rd_q ? IDLE_RP : IDLE_RN), COMMA} : word_q;
  assign ctl_out  = idle_q ? 2'b01 : ctl_q;
  assign disp_hi  = idle_q ? ~rd_q : (rd_q ^ flo_q);
  assign disp_end = idle_q ? 1'b0 : (disp_hi ^ fhi_q);

  AST_DATA_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    !idle_req |=> (word_out == $past(word_in) && ctl_out == $past(ctl_in))); // R2
  AST_RD_CHAIN: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (disp_lo == $past(disp_end))); // R5
  AST_IDLE_COMMA: assert property (@(posedge clk) disable iff (!rst_n)
    idle_req |=> (ctl_out == 2'b01 && word_out[7:0] == 8'hBC)); // R8
  AST_IDLE_PICK: assert property (@(posedge clk) disable iff (!rst_n)
    idle_req |=> (word_out[15:8] == (disp_lo ? 8'hC5 : 8'h50) && disp_hi != disp_lo)); // R8
  AST_IDLE_NEG: assert property (@(posedge clk) disable iff (!rst_n)
    idle_req ##1 1'b1 |=> !disp_lo); // R9

endmodule

// File: tb/rd_idle_sel_tb_top.sv
module rd_idle_sel_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic [15:0] word_in = '0;
  logic [1:0]  ctl_in = '0;
  logic        idle_req = 1'b0;
  logic [15:0] word_out;
  logic [1:0]  ctl_out;
  logic        disp_lo, disp_hi, disp_end;

  int n_chk = 0, n_fail = 0, n_i1 = 0, n_i2 = 0;
  logic rd_b = 1'b0;

  typedef struct packed {
    logic [15:0] w;
    logic [1:0]  c;
    logic        lo, hi, en, idle;
  } exp_t;
  exp_t q[$];

  always #5 clk = ~clk;

  rd_idle_sel dut_i (
    .clk(clk), .rst_n(rst_n), .word_in(word_in), .ctl_in(ctl_in), .idle_req(idle_req),
    .word_out(word_out), .ctl_out(ctl_out), .disp_lo(disp_lo), .disp_hi(disp_hi),
    .disp_end(disp_end)
  );

  localparam logic [31:0] UNBAL5 = 32'hE981_8117;

  function automatic logic bflip(input logic [7:0] b, input logic k);
    logic u3;
    u3 = (b[7:5] == 3'd0) || (b[7:5] == 3'd4) || (b[7:5] == 3'd7);
    return k ? 1'b1 : (UNBAL5[b[4:0]] ^ u3);
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [15:0] w, input logic [1:0] c, input logic idl);
    exp_t e;
    @(negedge clk);
    word_in = w; ctl_in = c; idle_req = idl;
    e.idle = idl;
    e.lo = rd_b;
    if (idl) begin
      e.w = {(rd_b ? 8'hC5 : 8'h50), 8'hBC};
      e.c = 2'b01;
      e.hi = ~rd_b;
      e.en = 1'b0;
      if (rd_b) n_i1++; else n_i2++;
    end else begin
      e.w = w;
      e.c = c;
      e.hi = rd_b ^ bflip(w[7:0], c[0]);
      e.en = e.hi ^ bflip(w[15:8], c[1]);
    end
    rd_b = e.en;
    q.push_back(e);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk);
      #1;
      if (rst_n && q.size() > 0) begin
        e = q.pop_front();
        chk(word_out == e.w, e.idle ? "R8 idle word" : "R2 word delay", word_out, e.w);
        chk(ctl_out == e.c, e.idle ? "R8 idle ctl" : "R2 ctl delay", {14'd0, ctl_out}, {14'd0, e.c});
        chk(disp_lo == e.lo, "R3/R9 low byte disparity", {15'd0, disp_lo}, {15'd0, e.lo});
        chk(disp_hi == e.hi, e.idle ? "R8 idle high disparity" : "R4/R6/R7 high byte disparity",
            {15'd0, disp_hi}, {15'd0, e.hi});
        chk(disp_end == e.en, e.idle ? "R9 end after idle" : "R5/R6/R7 end disparity",
            {15'd0, disp_end}, {15'd0, e.en});
      end
    end
  end

  initial begin : watchdog
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : stim
    #1 rst_n = 1'b0;
    word_in = 16'hFFFF;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk(disp_lo == 1'b0, "R1 reset disp_lo", {15'd0, disp_lo}, 16'd0);
    chk(disp_end == 1'b0, "R1 reset disp_end", {15'd0, disp_end}, 16'd0);
    chk(word_out == 16'd0, "R1 reset word_out", word_out, 16'd0);
    word_in = '0;
    rst_n = 1'b1;
    // directed: R6 flip cases, R7 control byte, R8 idle after both polarities
    drive(16'h0000, 2'b00, 1'b0);
    drive(16'h0003, 2'b00, 1'b0);
    drive(16'h1234, 2'b00, 1'b1);
    drive(16'h00BC, 2'b01, 1'b0);
    drive(16'hFFFF, 2'b00, 1'b1);
    drive(16'h0000, 2'b00, 1'b1);
    drive(16'hBC55, 2'b10, 1'b0);
    drive(16'h00E7, 2'b00, 1'b0);
    drive(16'h0001, 2'b00, 1'b1);
    drive(16'hBCBC, 2'b11, 1'b0);
    drive(16'h0000, 2'b00, 1'b0);
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] r;
      r = $urandom;
      drive(r[15:0], (r[19:16] == 4'd0) ? r[21:20] : 2'b00, r[24:22] < 3'd2);
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(q.size() == 0, "R2 scoreboard drained", 16'(q.size()), 16'd0);
    chk(n_i1 > 0, "R8 idle after positive seen", 16'(n_i1), 16'd1);
    chk(n_i2 > 0, "R8 idle after negative seen", 16'(n_i2), 16'd1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule